// File: doc/BRIEF.md
# Dyadic Pulse-Density Modulator

This block turns an unsigned code of `WIDTH` bits into a one-bit stream. Its average duty over a frame of 2^WIDTH clocks is exactly code/2^WIDTH. A plain pulse-width modulator would emit the high clocks as one wide pulse. This block instead spreads them across the frame. Each code bit of weight 2^k contributes 2^k high clocks, and those clocks are spaced evenly through the frame. After a simple analog low-pass filter the output gives a DC level proportional to the code, with less ripple than a PWM stream of the same width.

A free-running counter indexes the slots of the frame. The slot index is reversed bit for bit, and the reversed index is compared against the code. That is the whole datapath, so the logic cost stays close to a PWM of the same width: one counter, one comparator and a code holding register. The input code is captured once per frame, on the frame's first clock, which keeps the per-frame count exact when the input moves. The block is meant to be instantiated at 6-bit and at 8-bit resolution.

Top module: `ddpm_modulator`

## Requirements
- R1: While `rst_n` is 0 the output `pdm_o` is 0 and the slot counter is cleared. The first rising edge with `rst_n` at 1 begins a frame, and that frame follows R3 from slot 0.
- R2: Over every frame of 2^WIDTH consecutive slots, `pdm_o` is 1 in exactly `code` slots, where `code` is the value captured for that frame.
- R3: Slots are numbered s = 0 .. 2^WIDTH-1. Edge 0 of a frame is the rising edge that captures the code, and slot s is the clock period after edge s. In slot s, `pdm_o` is 1 exactly when rev(s) < code, where rev moves bit i of s to bit WIDTH-1-i.
- R4: Code 0 keeps `pdm_o` at 0 for the whole frame.
- R5: Code 2^WIDTH-1 keeps `pdm_o` at 1 in every slot except the last slot (s = 2^WIDTH-1), where it is 0.
- R6: `level_i` is sampled only on edge 0 of each frame. A change at any other time has no effect on the output until the next frame begins.
- R7: Code 2^(WIDTH-1) gives `pdm_o` = 1 in even slots and 0 in odd slots.
- R8: R2 and R3 hold with WIDTH set to 6 and with WIDTH set to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| level_i | input | WIDTH | Unsigned code that sets the duty of the next frame |
| pdm_o | output | 1 | Registered one-bit modulated stream |

## Verification
Two functions can fall in the same cycle: capturing a new code and deciding the output of slot 0. Both take place on edge 0 of a frame, so the code just captured must already govern slot 0, and a code written on the previous clock must win over the held one. The bench loads a new code on the last slot of every frame and judges slot 0 of the next frame against that new code. It also writes a conflicting code directly after slot 0, and again in the middle of a frame, and expects the whole frame to keep the old pattern and count. An exhaustive sweep of all 64 codes at 6 bits, plus a spread of codes at 8 bits, is judged slot by slot against the bit-reversal rule.

// File: rtl/ddpm_pkg.sv
package ddpm_pkg;

    // Frame length in clocks for a given code width.
    function automatic int unsigned frame_len(input int unsigned w);
        return 32'd1 << w;
    endfunction

    // Frame boundary marks produced by the slot counter.
    typedef struct packed {
        logic start;
        logic last;
    } frame_mark_t;

endpackage

// File: rtl/ddpm_frame_ctr.sv
module ddpm_frame_ctr
    import ddpm_pkg::*;
#(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] slot_o,
    output frame_mark_t      mark_o
);

    localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [WIDTH-1:0] slot;
    } ctr_state_t;

    ctr_state_t ctr_q;
    ctr_state_t ctr_d;

    always_comb begin
        ctr_d      = ctr_q;
        ctr_d.slot = ctr_q.slot + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign slot_o       = ctr_q.slot;
    assign mark_o.start = (ctr_q.slot == '0);
    assign mark_o.last  = (&ctr_q.slot);

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_o.last |=> mark_o.start);

endmodule

// File: rtl/ddpm_bitrev.sv
module ddpm_bitrev #(
    parameter int unsigned WIDTH = 6
) (
    input  logic [WIDTH-1:0] slot_i,
    output logic [WIDTH-1:0] rank_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_swap
        assign rank_o[i] = slot_i[WIDTH-1-i];
    end

endmodule

// File: rtl/ddpm_slot_cmp.sv
module ddpm_slot_cmp #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] rank_i,
    output logic [WIDTH-1:0] code_o,
    output logic             pdm_o
);

    localparam logic [WIDTH-1:0] CODE_FULL = '1;
    localparam logic [WIDTH-1:0] CODE_HALF = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] code;
        logic             pdm;
    } cmp_state_t;

    cmp_state_t st_q;
    cmp_state_t st_d;
    logic [WIDTH-1:0] code_eff;

    always_comb begin
        // On the frame's first edge the fresh level already governs slot 0.
        code_eff = start_i ? level_i : st_q.code;
        st_d      = st_q;
        st_d.code = code_eff;
        st_d.pdm  = (rank_i < code_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign pdm_o  = st_q.pdm;

    // R6
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(code_o));

    // R4
    zero_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && code_o == '0) |=> !pdm_o);

    // R5
    full_code_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && code_o == CODE_FULL && rank_i != CODE_FULL) |=> pdm_o);

    // R7
    half_code_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && code_o == CODE_HALF) |=> (pdm_o != $past(rank_i[WIDTH-1])));

endmodule

// File: rtl/ddpm_modulator.sv
module ddpm_modulator
    import ddpm_pkg::*;
#(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic             pdm_o
);

    localparam int unsigned FRAME = frame_len(WIDTH);
    localparam int unsigned ACC_W = $clog2(FRAME + 1);
    localparam logic [WIDTH-1:0] SLOT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] slot;
    logic [WIDTH-1:0] rank;
    logic [WIDTH-1:0] code;
    frame_mark_t      mark;

    ddpm_frame_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot),
        .mark_o (mark)
    );

    ddpm_bitrev #(.WIDTH(WIDTH)) u_rev (
        .slot_i (slot),
        .rank_o (rank)
    );

    ddpm_slot_cmp #(.WIDTH(WIDTH)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_i),
        .start_i (mark.start),
        .rank_i  (rank),
        .code_o  (code),
        .pdm_o   (pdm_o)
    );

    // Checker: ones seen on the output over one frame of slots.
    logic [ACC_W-1:0] ones_q;
    logic [ACC_W-1:0] pdm_ext;

    assign pdm_ext = {{(ACC_W-1){1'b0}}, pdm_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (slot == SLOT_ONE) begin
            ones_q <= pdm_ext;
        end else begin
            ones_q <= ones_q + pdm_ext;
        end
    end

    // R2
    frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark.start |-> ((ones_q + pdm_ext) == {{(ACC_W-WIDTH){1'b0}}, code}));

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pdm_o && mark.start));

endmodule

// File: tb/sim_ddpm_modulator.sv
module sim_ddpm_modulator;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst6_n = 1'b0;
    logic       rst8_n = 1'b0;
    logic [5:0] lvl6   = '0;
    logic [7:0] lvl8   = '0;
    logic       o6;
    logic       o8;

    ddpm_modulator #(.WIDTH(6)) u0 (
        .clk(clk), .rst_n(rst6_n), .level_i(lvl6), .pdm_o(o6)
    );

    ddpm_modulator #(.WIDTH(8)) u1 (
        .clk(clk), .rst_n(rst8_n), .level_i(lvl8), .pdm_o(o8)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rev(input int v, input int w);
        int r = 0;
        for (int i = 0; i < w; i++) begin
            if (v[i]) r = r | (1 << (w - 1 - i));
        end
        return r;
    endfunction

    task automatic set_lvl(input int w, input int c);
        if (w == 6) lvl6 = c[5:0];
        else        lvl8 = c[7:0];
    endtask

    function automatic int get_out(input int w);
        return (w == 6) ? int'(o6) : int'(o8);
    endfunction

    // Called at a falling edge just before a frame's edge 0.
    task automatic run_frame(input int w, input int code, input int chg_slot,
                             input int chg_code, input string tag);
        int len  = 1 << w;
        int ones = 0;
        set_lvl(w, code);
        for (int s = 0; s < len; s++) begin
            int o;
            @(posedge clk);
            @(negedge clk);
            o = get_out(w);
            ones += o;
            check($sformatf("%s w%0d code %0d slot %0d", tag, w, code, s),
                  o, (rev(s, w) < code) ? 1 : 0);
            if (s == chg_slot) set_lvl(w, chg_code);
        end
        check($sformatf("R2/%s w%0d code %0d frame ones", tag, w, code), ones, code);
    endtask

    function automatic string tag6(input int c);
        if (c == 0)  return "R4";
        if (c == 63) return "R5";
        if (c == 32) return "R7";
        return "R3";
    endfunction

    initial begin
        // R1: held in reset, output stays low whatever the level.
        lvl6 = 6'd37;
        lvl8 = 8'd200;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 reset w6", int'(o6), 0);
            check("R1 reset w8", int'(o8), 0);
        end
        rst6_n = 1'b1;
        run_frame(6, 37, -1, 0, "R1");

        // Exhaustive sweep at 6 bits (R3, R4, R5, R7).
        for (int c = 0; c < 64; c++) begin
            run_frame(6, c, -1, 0, tag6(c));
        end

        // R6: change mid-frame, and directly after the capture edge.
        run_frame(6, 10, 20, 50, "R6");
        run_frame(6, 5, 0, 60, "R6");
        run_frame(6, 60, 62, 3, "R6");

        // R1: reset in the middle of a frame, then a clean restart.
        lvl6 = 6'd45;
        for (int i = 0; i < 10; i++) @(negedge clk);
        rst6_n = 1'b0;
        #1;
        check("R1 mid-run reset w6", int'(o6), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 mid-run reset hold w6", int'(o6), 0);
        end
        rst6_n = 1'b1;
        run_frame(6, 45, -1, 0, "R1");

        // R8: the 8-bit instance.
        rst8_n = 1'b1;
        run_frame(8, 0, -1, 0, "R8");
        run_frame(8, 1, -1, 0, "R8");
        run_frame(8, 2, -1, 0, "R8");
        run_frame(8, 127, -1, 0, "R8");
        run_frame(8, 128, -1, 0, "R8");
        run_frame(8, 129, -1, 0, "R8");
        run_frame(8, 255, -1, 0, "R8");
        for (int c = 3; c < 256; c += 37) begin
            run_frame(8, c, -1, 0, "R8");
        end
        run_frame(8, 100, 77, 3, "R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule